// File: doc/BRIEF.md
# Tester Pin Stimulus Formatter

This block shapes the drive waveform of one tester channel. At each test-cycle start strobe it takes one vector symbol (drive 0, drive 1 or high impedance) and a waveform format. From these it produces the pin data value and the driver enable. Edge times inside the cycle are programmable delays, counted in clock ticks from the strobe. There is a leading-edge delay, a trailing-edge delay and an inhibit delay.

Five waveform shapes are available. Two of them hold the data for the rest of the cycle, one from tick 0 and one from a delayed edge. The other three return after the trailing edge: to logic low, to logic high, or to high impedance. A high-impedance vector keeps the previous drive until its inhibit delay and then releases the pin. A new run begins with the driver released. Reset marks the start of a run.

Top module: `pin_formatter`

## Requirements
- R1: Encodings are as follows. Symbol 2'b00 drives 0, 2'b01 drives 1, and 2'b10 or 2'b11 is high impedance (Z). Format 0 is NRZ, 1 is delayed NRZ, 2 is return-to-zero, 3 is return-to-one and 4 is return-to-inhibit; codes 5 to 7 behave as NRZ. Each input is captured on the clock edge where `cyc_start_i` is high. Tick 0 is the cycle that follows that edge, and an edge with delay d shows at tick d.
- R2: After reset, `pin_oe_o` is 0 and `pin_data_o` is 0. The driver stays released until a drive vector reaches its leading-edge tick.
- R3: NRZ drives the symbol from tick 0, whatever the programmed leading delay, and holds it until the next strobe.
- R4: Delayed NRZ keeps the previous output before the leading-edge tick. From that tick it drives the symbol, with enable 1, until the next strobe.
- R5: Return-to-zero drives the symbol from the leading tick. From the trailing tick it drives 0 with enable 1.
- R6: Return-to-one drives the symbol from the leading tick. From the trailing tick it drives 1 with enable 1.
- R7: Return-to-inhibit drives the symbol from the leading tick and releases the pin (enable 0) from the trailing tick. Its inhibit delay is always the leading-edge delay; the programmed inhibit value is ignored.
- R8: A Z vector keeps the previous data and enable until the inhibit tick. From that tick enable is 0 and data keeps its last value.
- R9: A Z vector with an effective inhibit delay of 0 holds the enable at 0 for the whole cycle.
- R10: When the trailing delay is not greater than the leading delay, the return phase is suppressed and the cycle behaves as a held drive.
- R11: A delay not reached before the next strobe never fires. A strobe in mid-cycle starts the next vector at once.
- R12: A Z vector never raises the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Synchronous active-low reset, marks run start |
| cyc_start_i | input | 1 | Test-cycle start strobe |
| vec_sym_i | input | 2 | Vector symbol |
| fmt_i | input | 3 | Waveform format select |
| dly_lead_i | input | TICK_W | Leading-edge delay in ticks |
| dly_trail_i | input | TICK_W | Trailing-edge delay in ticks |
| dly_inh_i | input | TICK_W | Inhibit delay in ticks |
| pin_data_o | output | 1 | Pin drive data |
| pin_oe_o | output | 1 | Driver enable |

## Verification
The assertions check four things on every cycle. The driver stays released before the first strobe. A Z vector never raises the enable. A zero effective inhibit releases the pin at tick 0. A drive vector with a zero leading edge shows its data at tick 0. Only the bench's scenarios can show the placement of delayed edges, the return value after the trailing edge and the carry-over of the previous output into a new cycle. The same holds for the substitution of the leading delay for the inhibit delay, the suppression of a trailing edge that comes too early, and a strobe arriving in mid-cycle.

// File: rtl/pf_pkg.sv
// Package: shared encodings for the pin stimulus formatter.
// Assumes two-bit symbols and three-bit format codes.
package pf_pkg;
    typedef enum logic [2:0] {
        FMT_NRZ  = 3'd0,
        FMT_DNRZ = 3'd1,
        FMT_RZ   = 3'd2,
        FMT_RO   = 3'd3,
        FMT_RINH = 3'd4
    } fmt_e;

    localparam logic [1:0] SYM_D0 = 2'b00;
    localparam logic [1:0] SYM_D1 = 2'b01;
    localparam logic [1:0] SYM_Z  = 2'b10;
endpackage

// File: rtl/pf_tick_counter.sv
// Tick counter: counts clock ticks since the last cycle start strobe.
// Assumes the strobe restarts the count at 0. The count saturates at its
// maximum, so it never wraps into an early edge.
module pf_tick_counter #(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [TICK_W-1:0] tick_o
);
    localparam logic [TICK_W-1:0] TICK_MAX = {TICK_W{1'b1}};

    // Purpose: restart on strobe, otherwise count up and saturate.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_o <= TICK_MAX;
        else if (start_i)
            tick_o <= '0;
        else if (tick_o != TICK_MAX)
            tick_o <= tick_o + 1'b1;
    end
endmodule

// File: rtl/pf_vector_latch.sv
// Vector latch: captures the symbol, format and effective delays at each
// strobe. It also records the output present at the strobe as the carried
// state. Assumes reset marks a run start, with the driver released.
module pf_vector_latch #(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        sym_i,
    input  logic [2:0]        fmt_i,
    input  logic [TICK_W-1:0] lead_i,
    input  logic [TICK_W-1:0] trail_i,
    input  logic [TICK_W-1:0] inh_i,
    input  logic              cur_data_i,
    input  logic              cur_oe_i,
    output logic              is_z_o,
    output logic              bit_o,
    output pf_pkg::fmt_e      fmt_o,
    output logic [TICK_W-1:0] lead_o,
    output logic [TICK_W-1:0] trail_o,
    output logic [TICK_W-1:0] inh_o,
    output logic              held_data_o,
    output logic              held_oe_o
);
    import pf_pkg::*;

    fmt_e              fmt_n;
    logic [TICK_W-1:0] lead_n;
    logic [TICK_W-1:0] inh_n;

    // Purpose: fold unused codes to NRZ, zero the NRZ lead, tie the inhibit to the lead for return-to-inhibit.
    always_comb begin
        case (fmt_i)
            3'd1:    fmt_n = FMT_DNRZ;
            3'd2:    fmt_n = FMT_RZ;
            3'd3:    fmt_n = FMT_RO;
            3'd4:    fmt_n = FMT_RINH;
            default: fmt_n = FMT_NRZ;
        endcase
        lead_n = (fmt_n == FMT_NRZ) ? '0 : lead_i;
        inh_n  = (fmt_n == FMT_RINH) ? lead_n : inh_i;
    end

    // Purpose: latch vector settings and carried output at each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_z_o      <= 1'b1;
            bit_o       <= 1'b0;
            fmt_o       <= FMT_NRZ;
            lead_o      <= '0;
            trail_o     <= '0;
            inh_o       <= '0;
            held_data_o <= 1'b0;
            held_oe_o   <= 1'b0;
        end else if (start_i) begin
            is_z_o      <= sym_i[1];
            bit_o       <= sym_i[0];
            fmt_o       <= fmt_n;
            lead_o      <= lead_n;
            trail_o     <= trail_i;
            inh_o       <= inh_n;
            held_data_o <= cur_data_i;
            held_oe_o   <= cur_oe_i;
        end
    end
endmodule

// File: rtl/pf_wave_gen.sv
// Wave generator: turns the latched vector and the tick count into pin
// data and enable. It is purely combinational. Assumes the latched delays
// are already effective values.
module pf_wave_gen #(
    parameter int TICK_W = 8
) (
    input  logic              is_z_i,
    input  logic              bit_i,
    input  pf_pkg::fmt_e      fmt_i,
    input  logic [TICK_W-1:0] lead_i,
    input  logic [TICK_W-1:0] trail_i,
    input  logic [TICK_W-1:0] inh_i,
    input  logic [TICK_W-1:0] tick_i,
    input  logic              held_data_i,
    input  logic              held_oe_i,
    output logic              data_o,
    output logic              oe_o
);
    import pf_pkg::*;

    logic is_return;
    logic ret_on;

    // Purpose: choose the output phase (held, drive or return) for the current tick.
    always_comb begin
        is_return = (fmt_i == FMT_RZ) || (fmt_i == FMT_RO) || (fmt_i == FMT_RINH);
        ret_on    = is_return && (trail_i > lead_i) && (tick_i >= trail_i);
        data_o    = held_data_i;
        oe_o      = held_oe_i;
        if (is_z_i) begin
            if (tick_i >= inh_i)
                oe_o = 1'b0;
        end else if (tick_i >= lead_i) begin
            data_o = bit_i;
            oe_o   = 1'b1;
            if (ret_on) begin
                case (fmt_i)
                    FMT_RZ:  data_o = 1'b0;
                    FMT_RO:  data_o = 1'b1;
                    default: oe_o   = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/pin_formatter.sv
// Pin formatter top: one tester channel's stimulus shaper. The outputs
// follow the tick counter combinationally, so an edge with delay d shows
// at tick d. Assumes every input is stable at the strobe edge.
module pin_formatter #(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start_i,
    input  logic [1:0]        vec_sym_i,
    input  logic [2:0]        fmt_i,
    input  logic [TICK_W-1:0] dly_lead_i,
    input  logic [TICK_W-1:0] dly_trail_i,
    input  logic [TICK_W-1:0] dly_inh_i,
    output logic              pin_data_o,
    output logic              pin_oe_o
);
    logic [TICK_W-1:0] tick;
    logic              v_is_z, v_bit, held_data, held_oe;
    pf_pkg::fmt_e      v_fmt;
    logic [TICK_W-1:0] v_lead, v_trail, v_inh;

    pf_tick_counter #(.TICK_W(TICK_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start_i(cyc_start_i), .tick_o(tick)
    );

    pf_vector_latch #(.TICK_W(TICK_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .start_i(cyc_start_i),
        .sym_i(vec_sym_i), .fmt_i(fmt_i),
        .lead_i(dly_lead_i), .trail_i(dly_trail_i), .inh_i(dly_inh_i),
        .cur_data_i(pin_data_o), .cur_oe_i(pin_oe_o),
        .is_z_o(v_is_z), .bit_o(v_bit), .fmt_o(v_fmt),
        .lead_o(v_lead), .trail_o(v_trail), .inh_o(v_inh),
        .held_data_o(held_data), .held_oe_o(held_oe)
    );

    pf_wave_gen #(.TICK_W(TICK_W)) u_wave (
        .is_z_i(v_is_z), .bit_i(v_bit), .fmt_i(v_fmt),
        .lead_i(v_lead), .trail_i(v_trail), .inh_i(v_inh),
        .tick_i(tick), .held_data_i(held_data), .held_oe_i(held_oe),
        .data_o(pin_data_o), .oe_o(pin_oe_o)
    );
endmodule

// File: rtl/pf_checker.sv
// Checker: port-level properties of the pin formatter, bound to every
// instance. Assumes the same encodings as the design.
module pf_checker #(
    parameter int TICK_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_start_i,
    input logic [1:0]        vec_sym_i,
    input logic [2:0]        fmt_i,
    input logic [TICK_W-1:0] dly_lead_i,
    input logic [TICK_W-1:0] dly_inh_i,
    input logic              pin_data_o,
    input logic              pin_oe_o
);
    logic seen_start;
    logic active_z;

    // Purpose: track whether a strobe has arrived and whether the active vector is Z.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_start <= 1'b0;
            active_z   <= 1'b1;
        end else if (cyc_start_i) begin
            seen_start <= 1'b1;
            active_z   <= vec_sym_i[1];
        end
    end

    assert_idle_before_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_start |-> !pin_oe_o);

    assert_z_no_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        active_z |-> !$rose(pin_oe_o));

    assert_zero_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start_i && vec_sym_i[1] &&
         ((fmt_i == 3'd4) ? (dly_lead_i == '0) : (dly_inh_i == '0)))
        |=> !pin_oe_o);

    assert_tick0_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start_i && !vec_sym_i[1] && (fmt_i == 3'd0 || dly_lead_i == '0))
        |=> (pin_oe_o && pin_data_o == $past(vec_sym_i[0])));
endmodule

bind pin_formatter pf_checker #(.TICK_W(TICK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cyc_start_i(cyc_start_i),
    .vec_sym_i(vec_sym_i), .fmt_i(fmt_i),
    .dly_lead_i(dly_lead_i), .dly_inh_i(dly_inh_i),
    .pin_data_o(pin_data_o), .pin_oe_o(pin_oe_o)
);

// File: tb/sim_pin_formatter.sv
// Directed bench for the pin formatter: one task per scenario.
module sim_pin_formatter;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_start_i = 1'b0;
    logic [1:0]    vec_sym_i = 2'b00;
    logic [2:0]    fmt_i = 3'd0;
    logic [TW-1:0] dly_lead_i = '0;
    logic [TW-1:0] dly_trail_i = '0;
    logic [TW-1:0] dly_inh_i = '0;
    logic          pin_data_o, pin_oe_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    pin_formatter #(.TICK_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_start_i(cyc_start_i),
        .vec_sym_i(vec_sym_i), .fmt_i(fmt_i),
        .dly_lead_i(dly_lead_i), .dly_trail_i(dly_trail_i), .dly_inh_i(dly_inh_i),
        .pin_data_o(pin_data_o), .pin_oe_o(pin_oe_o)
    );

    task automatic chk(input string req, input logic exp_oe, input logic exp_d);
        n_tests++;
        if (pin_oe_o !== exp_oe || pin_data_o !== exp_d) begin
            n_fail++;
            $display("FAIL %s: oe/data got %b/%b expected %b/%b",
                     req, pin_oe_o, pin_data_o, exp_oe, exp_d);
        end
    endtask

    // Strobe a vector; returns at the negedge of tick 0.
    task automatic start_vec(input logic [1:0] s, input logic [2:0] f,
                             input int ld, input int tr, input int ih);
        vec_sym_i   = s;
        fmt_i       = f;
        dly_lead_i  = TW'(ld);
        dly_trail_i = TW'(tr);
        dly_inh_i   = TW'(ih);
        cyc_start_i = 1'b1;
        @(negedge clk);
        cyc_start_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R2 reset", 1'b0, 1'b0);
        ticks(3);
        chk("R2 idle", 1'b0, 1'b0);
    endtask

    task automatic t_first_dnrz();
        start_vec(2'b01, 3'd1, 3, 0, 0);
        chk("R2 first vector released", 1'b0, 1'b0);
        ticks(2);
        chk("R2 before lead", 1'b0, 1'b0);
        ticks(1);
        chk("R4 lead edge", 1'b1, 1'b1);
    endtask

    task automatic t_nrz();
        start_vec(2'b00, 3'd0, 5, 0, 0);
        chk("R3 tick0", 1'b1, 1'b0);
        ticks(8);
        chk("R3 hold", 1'b1, 1'b0);
    endtask

    task automatic t_dnrz();
        start_vec(2'b01, 3'd1, 4, 0, 0);
        ticks(1);
        chk("R4 held before lead", 1'b1, 1'b0);
        ticks(3);
        chk("R4 at lead", 1'b1, 1'b1);
    endtask

    task automatic t_rz();
        start_vec(2'b01, 3'd2, 2, 5, 0);
        ticks(4);
        chk("R5 data phase", 1'b1, 1'b1);
        ticks(1);
        chk("R5 return low", 1'b1, 1'b0);
    endtask

    task automatic t_ro();
        start_vec(2'b00, 3'd3, 2, 5, 0);
        ticks(1);
        chk("R4 held carry", 1'b1, 1'b0);
        ticks(2);
        chk("R6 data phase", 1'b1, 1'b0);
        ticks(2);
        chk("R6 return high", 1'b1, 1'b1);
    endtask

    task automatic t_z_inh();
        start_vec(2'b10, 3'd0, 0, 0, 3);
        ticks(1);
        chk("R8 held before inhibit", 1'b1, 1'b1);
        ticks(2);
        chk("R8 released at inhibit", 1'b0, 1'b1);
    endtask

    task automatic t_z_zero();
        start_vec(2'b00, 3'd0, 0, 0, 0);
        ticks(2);
        start_vec(2'b11, 3'd0, 0, 0, 0);
        chk("R9 tick0 released", 1'b0, 1'b0);
        ticks(5);
        chk("R9 still released", 1'b0, 1'b0);
    endtask

    task automatic t_z_never();
        start_vec(2'b10, 3'd1, 0, 0, 4);
        chk("R12 tick0", 1'b0, 1'b0);
        ticks(6);
        chk("R12 after inhibit", 1'b0, 1'b0);
    endtask

    task automatic t_rinh();
        start_vec(2'b01, 3'd4, 2, 4, 9);
        chk("R7 held released", 1'b0, 1'b0);
        ticks(2);
        chk("R7 drive", 1'b1, 1'b1);
        ticks(2);
        chk("R7 return inhibit", 1'b0, 1'b1);
        start_vec(2'b00, 3'd0, 0, 0, 0);
        ticks(1);
        start_vec(2'b10, 3'd4, 1, 0, 7);
        chk("R7 Z held", 1'b1, 1'b0);
        ticks(1);
        chk("R7 inhibit at lead", 1'b0, 1'b0);
    endtask

    task automatic t_trail_le();
        start_vec(2'b01, 3'd2, 4, 4, 0);
        ticks(6);
        chk("R10 no return equal", 1'b1, 1'b1);
        start_vec(2'b00, 3'd4, 3, 2, 0);
        ticks(5);
        chk("R10 no return less", 1'b1, 1'b0);
    endtask

    task automatic t_far();
        start_vec(2'b01, 3'd0, 0, 0, 0);
        ticks(1);
        start_vec(2'b00, 3'd1, 200, 0, 0);
        ticks(10);
        chk("R11 far edge unfired", 1'b1, 1'b1);
        start_vec(2'b00, 3'd7, 9, 0, 0);
        chk("R11 mid-cycle restart as NRZ", 1'b1, 1'b0);
    endtask

    initial begin : wdog
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        ticks(3);
        rst_n = 1'b1;
        t_reset();
        t_first_dnrz();
        t_nrz();
        t_dnrz();
        t_rz();
        t_ro();
        t_z_inh();
        t_z_zero();
        t_z_never();
        t_rinh();
        t_trail_le();
        t_far();
        // R1: encodings are exercised above (symbols 00/01/10/11, formats 0-4 and 7).
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule